// File: doc/BRIEF.md
# Quadrature Polynomial-Interpolated Frequency Synthesizer

This block is a direct digital frequency synthesizer that emits a matched pair of 16-bit signed samples, one sine and one cosine, from a 32-bit phase accumulator. A frequency tuning word is captured whenever the sample-enable input is high. The accumulator adds the captured word on every clock, so the output frequency is `f_clk * word / 2^32`.

The amplitude is not read from a full sine table. The two top phase bits choose a quadrant. The next six bits choose one of 64 equal segments of that quadrant, and twelve bits below them give the offset inside the segment. A 65-entry table of anchor amplitudes, computed at elaboration time, gives the sine and cosine at the start of the segment. A second-order Taylor expansion about that anchor is then evaluated as a small complex rotation, `(c + j s)(w + j u)`, where `u` is the offset angle and `w = 1 - u^2/2`. Three shared multipliers form both quadrature products. The first-quadrant result is mapped to the full circle by swapping and negating.

The pipeline has a fixed depth. It is meant to feed a mixer or a converter that takes one sample pair per clock and a qualifying valid flag.

Top module: `ddfs_quad_synth`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the accumulator and the captured tuning word to 0, and drives `sin_out` = 0, `cos_out` = 0 and `out_valid` = 0.
- R2: `tune_word` is captured only at an edge where `sample_en` is 1. At other edges `tune_word` is ignored and the previously captured increment stays in use.
- R3: The accumulator is 32 bits wide. It adds the captured increment at every clock edge out of reset, whatever `sample_en` is, and wraps modulo 2^32.
- R4: With P the accumulator value after edge n, the outputs after edge n+5 are within 2 LSB of `32767*sin(2*pi*P/2^32)` and `32767*cos(2*pi*P/2^32)`.
- R5: `out_valid` after edge n+5 equals the value of `sample_en` at edge n, which is the same edge that produced the phase shown in that sample.
- R6: The phase bits are used as follows. Bits 31:30 select the quadrant, bits 29:24 the segment and bits 23:12 the in-segment offset. Bits 11:0 are discarded, so two phases that differ only in bits 11:0 give identical output pairs.
- R7: Two phases that differ only in bit 31 (half a turn apart) give output pairs that are exact negations of each other.
- R8: Both outputs are saturated to the symmetric range -32767..32767. The code -32768 never appears.
- R9: With a captured tuning word of 0, the phase holds still and the output pair stays constant from sample to sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Captures `tune_word` and marks the sample produced from this edge as valid |
| tune_word | input | 32 | Phase increment per clock (frequency tuning word) |
| sin_out | output | 16 | Signed sine sample, full scale 32767 |
| cos_out | output | 16 | Signed cosine sample, full scale 32767 |
| out_valid | output | 1 | Qualifies the current sample pair; `sample_en` delayed by the pipeline |

## Verification
The in-line checks assume that `rst` is held for at least one clock edge before any checked behaviour. The latency and amplitude-circle properties wait until five clean edges have passed since reset, so they never look at pipeline contents from before reset. No property restricts `sample_en` or `tune_word`. Any pattern of enables and any 32-bit word is legal. The stimulus therefore holds reset for eight cycles and changes inputs only on the falling clock edge. It then covers a zero word, a word of 1, a half-turn word, an irrational-ratio sweep word, a quarter-turn-plus word, and a stretch where `sample_en` toggles while `tune_word` carries unrelated values.

// File: rtl/ddfs_pkg.sv
package ddfs_pkg;

    // Phase and amplitude geometry
    localparam int PHASE_W  = 32;                   // accumulator width
    localparam int SEG_BITS = 6;                    // segments per quadrant = 2^SEG_BITS
    localparam int OFF_W    = 12;                   // kept in-segment offset bits
    localparam int OUT_W    = 16;                   // output sample width
    localparam int GUARD    = 3;                    // extra fraction bits on anchors
    localparam int FRAC     = 18;                   // fraction bits of angle terms
    localparam int WIDE     = 48;                   // internal arithmetic width

    localparam int SEGS     = 1 << SEG_BITS;
    localparam int KEEP_W   = 2 + SEG_BITS + OFF_W; // phase bits the datapath consumes
    localparam int ANCH_W   = OUT_W + GUARD + 1;
    localparam int FULL     = (1 << (OUT_W - 1)) - 1;
    localparam int SH       = FRAC + GUARD;         // final scaling shift
    localparam real PI_R    = 3.14159265358979323846;

    typedef enum logic [1:0] {Q_FIRST, Q_SECOND, Q_THIRD, Q_FOURTH} quad_e;

    typedef logic signed [ANCH_W-1:0] anch_t;
    typedef logic signed [WIDE-1:0]   wide_t;
    typedef logic signed [OUT_W-1:0]  samp_t;

    // Stage 1: segment anchors fetched
    typedef struct packed {
        logic             vld;
        quad_e            quad;
        anch_t            s;
        anch_t            c;
        logic [OFF_W-1:0] off;
    } seg_stage_t;

    // Stage 2: offset converted to an angle
    typedef struct packed {
        logic  vld;
        quad_e quad;
        anch_t s;
        anch_t c;
        wide_t u;
    } ang_stage_t;

    // Stage 3: second-order term folded into w = 1 - u^2/2
    typedef struct packed {
        logic  vld;
        quad_e quad;
        anch_t s;
        anch_t c;
        wide_t u;
        wide_t w;
    } rot_stage_t;

    // Stage 4: three shared products
    typedef struct packed {
        logic  vld;
        quad_e quad;
        wide_t k1;
        wide_t k2;
        wide_t k3;
    } prod_stage_t;

    // Odd power series, ample precision on [0, pi/2]
    function automatic real poly_sin(real x);
        real term;
        real acc;
        term = x;
        acc  = x;
        for (int n = 1; n < 9; n++) begin
            term = -term * x * x / real'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Anchor amplitude at segment boundary j of the first quadrant
    function automatic int anchor_val(int j);
        real a;
        a = real'(FULL * (2 ** GUARD)) * poly_sin(PI_R * real'(j) / real'(2 * SEGS));
        return int'($floor(a + 0.5));
    endfunction

    // Segment width in radians, scaled by 2^FRAC
    function automatic int step_const();
        return int'($floor(PI_R / real'(2 * SEGS) * real'(2 ** FRAC) + 0.5));
    endfunction

    localparam int K_STEP = step_const();

    // Round to nearest, then clamp to the symmetric output range
    function automatic samp_t sat_round(wide_t v);
        wide_t r;
        r = (v + (wide_t'(1) <<< (SH - 1))) >>> SH;
        if (r > wide_t'(FULL))
            return samp_t'(FULL);
        else if (r < -wide_t'(FULL))
            return samp_t'(-FULL);
        return samp_t'(r);
    endfunction

endpackage

// File: rtl/ddfs_phase_accum.sv
module ddfs_phase_accum
    import ddfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_en,
    input  logic [PHASE_W-1:0] tune_word,
    output logic [KEEP_W-1:0]  ph_top,
    output logic               en_q
);

    logic [PHASE_W-1:0] ph_q;
    logic [PHASE_W-1:0] ftw_q;
    logic               primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= '0;
            ftw_q    <= '0;
            en_q     <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            ph_q     <= ph_q + ftw_q;
            en_q     <= sample_en;
            primed_q <= 1'b1;
            if (sample_en)
                ftw_q <= tune_word;
        end
    end

    assign ph_top = ph_q[PHASE_W-1 -: KEEP_W];

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        primed_q |-> ph_q == $past(ph_q) + $past(ftw_q));

    // R2
    ftw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (primed_q && !$past(sample_en)) |-> ftw_q == $past(ftw_q));

endmodule

// File: rtl/ddfs_seg_lookup.sv
module ddfs_seg_lookup
    import ddfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [KEEP_W-1:0] ph_top,
    input  logic              en_q,
    output seg_stage_t        st_q
);

    anch_t tbl [0:SEGS];

    for (genvar j = 0; j <= SEGS; j++) begin : g_tbl
        assign tbl[j] = anch_t'(anchor_val(j));
    end

    logic [SEG_BITS-1:0] seg;
    logic [SEG_BITS:0]   sidx;
    logic [SEG_BITS:0]   cidx;

    assign seg  = ph_top[KEEP_W-3 -: SEG_BITS];
    assign sidx = {1'b0, seg};
    assign cidx = (SEG_BITS + 1)'(SEGS) - sidx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.vld  <= en_q;
            st_q.quad <= quad_e'(ph_top[KEEP_W-1 -: 2]);
            st_q.s    <= tbl[sidx];
            st_q.c    <= tbl[cidx];
            st_q.off  <= ph_top[OFF_W-1:0];
        end
    end

endmodule

// File: rtl/ddfs_taylor_rot.sv
module ddfs_taylor_rot
    import ddfs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  seg_stage_t  st_q,
    output prod_stage_t p4_q
);

    ang_stage_t a2_q;
    rot_stage_t a3_q;

    // Stage 2: offset -> angle u (scaled by 2^FRAC)
    wide_t u_pre;
    assign u_pre = (wide_t'(st_q.off) * wide_t'(K_STEP) + (wide_t'(1) <<< (OFF_W - 1))) >>> OFF_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            a2_q <= '0;
        end else begin
            a2_q.vld  <= st_q.vld;
            a2_q.quad <= st_q.quad;
            a2_q.s    <= st_q.s;
            a2_q.c    <= st_q.c;
            a2_q.u    <= u_pre;
        end
    end

    // Stage 3: w = 1 - u^2/2 carries the second-order term
    wide_t sq;
    wide_t w_pre;
    assign sq    = a2_q.u * a2_q.u;
    assign w_pre = (wide_t'(1) <<< FRAC) - ((sq + (wide_t'(1) <<< FRAC)) >>> (FRAC + 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            a3_q <= '0;
        end else begin
            a3_q.vld  <= a2_q.vld;
            a3_q.quad <= a2_q.quad;
            a3_q.s    <= a2_q.s;
            a3_q.c    <= a2_q.c;
            a3_q.u    <= a2_q.u;
            a3_q.w    <= w_pre;
        end
    end

    // Stage 4: (c + j s)(w + j u) with three multipliers
    wide_t cs_sum;
    wide_t u_minus_w;
    wide_t u_plus_w;
    assign cs_sum    = wide_t'(a3_q.c) + wide_t'(a3_q.s);
    assign u_minus_w = a3_q.u - a3_q.w;
    assign u_plus_w  = a3_q.u + a3_q.w;

    always_ff @(posedge clk) begin
        if (rst) begin
            p4_q <= '0;
        end else begin
            p4_q.vld  <= a3_q.vld;
            p4_q.quad <= a3_q.quad;
            p4_q.k1   <= a3_q.w * cs_sum;
            p4_q.k2   <= wide_t'(a3_q.c) * u_minus_w;
            p4_q.k3   <= wide_t'(a3_q.s) * u_plus_w;
        end
    end

    // R6
    ofs_range_chk: assert property (@(posedge clk) disable iff (rst)
        (a2_q.u >= 0) && (a2_q.u <= wide_t'(K_STEP)));

endmodule

// File: rtl/ddfs_quad_synth.sv
module ddfs_quad_synth
    import ddfs_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_en,
    input  logic [31:0]              tune_word,
    output logic signed [15:0]       sin_out,
    output logic signed [15:0]       cos_out,
    output logic                     out_valid
);

    logic [KEEP_W-1:0] ph_top;
    logic              en_q;
    seg_stage_t        st_q;
    prod_stage_t       p4_q;

    ddfs_phase_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .tune_word (tune_word),
        .ph_top    (ph_top),
        .en_q      (en_q)
    );

    ddfs_seg_lookup u_lookup (
        .clk    (clk),
        .rst    (rst),
        .ph_top (ph_top),
        .en_q   (en_q),
        .st_q   (st_q)
    );

    ddfs_taylor_rot u_rot (
        .clk  (clk),
        .rst  (rst),
        .st_q (st_q),
        .p4_q (p4_q)
    );

    // Stage 5: recombine, round, saturate, unfold the quadrant
    wide_t sin_pre;
    wide_t cos_pre;
    samp_t s_sat;
    samp_t c_sat;
    samp_t sin_map;
    samp_t cos_map;

    assign sin_pre = p4_q.k1 + p4_q.k2;
    assign cos_pre = p4_q.k1 - p4_q.k3;
    assign s_sat   = sat_round(sin_pre);
    assign c_sat   = sat_round(cos_pre);

    always_comb begin
        unique case (p4_q.quad)
            Q_FIRST:  begin sin_map = s_sat;  cos_map = c_sat;  end
            Q_SECOND: begin sin_map = c_sat;  cos_map = -s_sat; end
            Q_THIRD:  begin sin_map = -s_sat; cos_map = -c_sat; end
            default:  begin sin_map = -c_sat; cos_map = s_sat;  end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_out   <= '0;
            cos_out   <= '0;
            out_valid <= 1'b0;
        end else begin
            sin_out   <= sin_map;
            cos_out   <= cos_map;
            out_valid <= p4_q.vld;
        end
    end

    // Clean edges since reset, saturating at the pipeline depth
    logic [2:0] live_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            live_cnt <= '0;
        else if (live_cnt != 3'd5)
            live_cnt <= live_cnt + 3'd1;
    end

    localparam longint R_LO = longint'(FULL - 3) * longint'(FULL - 3);
    localparam longint R_HI = longint'(FULL + 3) * longint'(FULL + 3);

    // R5
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (live_cnt == 3'd5) |-> out_valid == $past(en_q, 5));

    // R8
    sat_range_chk: assert property (@(posedge clk) disable iff (rst)
        (sin_out != 16'sh8000) && (cos_out != 16'sh8000));

    // R4
    circle_chk: assert property (@(posedge clk) disable iff (rst)
        (live_cnt == 3'd5) |->
            ((longint'(sin_out) * longint'(sin_out) + longint'(cos_out) * longint'(cos_out)) >= R_LO) &&
            ((longint'(sin_out) * longint'(sin_out) + longint'(cos_out) * longint'(cos_out)) <= R_HI));

endmodule

// File: tb/tb_ddfs_quad_synth.sv
module tb_ddfs_quad_synth;

    logic               clk = 1'b0;
    logic               rst;
    logic               sample_en;
    logic [31:0]        tune_word;
    logic signed [15:0] sin_out;
    logic signed [15:0] cos_out;
    logic               out_valid;

    always #5 clk = ~clk;

    ddfs_quad_synth dut (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .tune_word (tune_word),
        .sin_out   (sin_out),
        .cos_out   (cos_out),
        .out_valid (out_valid)
    );

    int    checks = 0;
    int    errors = 0;
    string tag    = "R3/R4";

    typedef struct {
        logic [31:0] ph;
        bit          en;
        bit          live;
    } ent_t;

    ent_t        hist[$];
    logic [31:0] m_ph  = '0;
    logic [31:0] m_ftw = '0;

    // Behavioural model: one entry per rising edge
    always @(posedge clk) begin
        ent_t e;
        if (rst) begin
            m_ph  = '0;
            m_ftw = '0;
            e.en   = 1'b0;
            e.live = 1'b0;
        end else begin
            m_ph = m_ph + m_ftw;
            e.en = sample_en;
            if (sample_en)
                m_ftw = tune_word;
            e.live = 1'b1;
        end
        e.ph = m_ph;
        hist.push_back(e);
        if (hist.size() > 6)
            void'(hist.pop_front());
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    ent_t        prev_e;
    bit          prev_ok = 1'b0;
    int          prev_s  = 0;
    int          prev_c  = 0;

    always @(negedge clk) begin
        if (rst) begin
            check(sin_out == 0, "R1", "sin_out in reset", sin_out, 0);
            check(cos_out == 0, "R1", "cos_out in reset", cos_out, 0);
            check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
            prev_ok = 1'b0;
        end else if (hist.size() == 6) begin
            ent_t e;
            e = hist[0];
            check(out_valid == e.en, "R5", "out_valid", out_valid, e.en);
            if (e.live) begin
                real ang;
                real es;
                real ec;
                int  xs;
                int  xc;
                ang = 2.0 * 3.14159265358979323846 * real'(e.ph) / 4294967296.0;
                es  = 32767.0 * $sin(ang);
                ec  = 32767.0 * $cos(ang);
                xs  = int'($floor(es + 0.5));
                xc  = int'($floor(ec + 0.5));
                check((real'(sin_out) - es <= 2.0) && (es - real'(sin_out) <= 2.0),
                      tag, "sin_out", sin_out, xs);
                check((real'(cos_out) - ec <= 2.0) && (ec - real'(cos_out) <= 2.0),
                      tag, "cos_out", cos_out, xc);
                check((sin_out != -16'sd32768) && (cos_out != -16'sd32768),
                      "R8", "saturation", sin_out, cos_out);
                if (prev_ok) begin
                    if (e.ph == prev_e.ph) begin
                        check(sin_out == prev_s, "R9", "held sin", sin_out, prev_s);
                        check(cos_out == prev_c, "R9", "held cos", cos_out, prev_c);
                    end else if (e.ph[31:12] == prev_e.ph[31:12]) begin
                        check(sin_out == prev_s, "R6", "low bits sin", sin_out, prev_s);
                        check(cos_out == prev_c, "R6", "low bits cos", cos_out, prev_c);
                    end else if (e.ph == (prev_e.ph ^ 32'h8000_0000)) begin
                        check(sin_out == -prev_s, "R7", "half-turn sin", sin_out, -prev_s);
                        check(cos_out == -prev_c, "R7", "half-turn cos", cos_out, -prev_c);
                    end
                end
                prev_e  = e;
                prev_s  = sin_out;
                prev_c  = cos_out;
                prev_ok = 1'b1;
            end
        end
    end

    task automatic run_word(input int n, input logic [31:0] w);
        sample_en = 1'b1;
        tune_word = w;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst       = 1'b1;
        sample_en = 1'b0;
        tune_word = '0;
        repeat (8) @(negedge clk);
        rst = 1'b0;

        tag = "R9";
        run_word(30, 32'h0000_0000);
        tag = "R3/R4";
        run_word(40, 32'h0000_0001);
        tag = "R7";
        run_word(30, 32'h8000_0000);
        tag = "R3/R4";
        run_word(3000, 32'h9E37_79B9);
        run_word(40, 32'h4000_1000);

        // Enable toggles; unrelated words while disabled must be ignored
        tag = "R2";
        for (int i = 0; i < 2000; i++) begin
            if (i % 3 == 0) begin
                sample_en = 1'b1;
                tune_word = 32'h0123_4567;
            end else begin
                sample_en = 1'b0;
                tune_word = 32'h5A5A_0000 ^ (32'(i) * 32'h0000_9E37);
            end
            @(negedge clk);
        end

        tag = "R5";
        sample_en = 1'b0;
        tune_word = 32'hFFFF_FFFF;
        repeat (12) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R5 watchdog: actual=%0d cycles expected=run to end", 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule